// File: doc/BRIEF.md
# Four-Mode Down-Counting Timer with Pin Gating

This block is a down-counter with a reload latch that runs in one of four modes. A mode register selects the mode and also holds a stop control, a polarity control and an enable for a secondary pin. In the plain and pulse modes the counter steps on each cycle of an external count-enable tick. In event mode it steps on edges of an external pin instead. In width mode the tick is counted only while the pin sits at the chosen level, so the count left in the counter shows how long the pin stayed there. Every underflow reloads the counter from the latch and raises a timer request flag.

The external pin passes through a synchronizer. A single polarity bit then derives one qualified pin level from it. A rising edge of that level raises the pin request flag. A falling edge of it is the counting event in event mode. A low qualified level gates counting in width mode. Because the polarity bit feeds that level directly, changing the bit can raise the pin request by itself. Software clears such a request by writing zero to the flag register. In pulse mode an output toggles on every underflow, and an inverted copy of it can be driven onto a second pin.

Registers are written through a simple write strobe with a 2-bit address: 0 is the counter, 1 is the mode register and 2 is the flag register. Address 3 is ignored.

Top module: `modal_timer`

## Requirements
- R1: After reset the counter and the reload latch hold all ones. The mode register reads 0. Both request flags are 0. The pulse output is 0 and the secondary-pin enable is 0.
- R2: The mode register layout is: bits [1:0] mode (00 plain, 01 pulse, 10 event, 11 width), bit 2 stop, bit 3 polarity, bit 4 secondary-pin enable. Bits above 4 always read back as 0.
- R3: In plain mode the counter decrements once for each tick. The pin level has no effect.
- R4: In width mode, with polarity 0 the counter decrements on ticks only while the pin is high. With polarity 1 it decrements only while the pin is low. At the other level it holds.
- R5: In event mode, with polarity 0 each rising pin edge decrements the counter once, and with polarity 1 each falling pin edge does. Ticks have no effect in this mode.
- R6: While the stop bit is 1 the counter does not change in any mode, except through a counter write.
- R7: A counting step taken at count 0 reloads the counter from the latch and sets the timer request flag (flag bit 0).
- R8: In pulse mode, and only in that mode, each underflow toggles the pulse output. When the secondary-pin enable is 1, the secondary pin carries the inverse of the pulse output and its enable output is 1.
- R9: With polarity 0 a falling pin edge sets the pin request flag (flag bit 1). With polarity 1 a rising pin edge sets it. The opposite edge leaves the flag alone.
- R10: Changing the polarity bit from 0 to 1 while the pin is high sets the pin request flag. Changing it from 0 to 1 while the pin is low does not. Writing 0 to the flag register clears both flags.
- R11: A counter write always loads the latch. It also loads the counter only while the stop bit is 1. While the counter runs, the written value takes effect at the next underflow.
- R12: The pin is sampled through two synchronizing flops before any edge or level is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable tick from the count source |
| pin_i | input | 1 | External asynchronous pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 counter, 1 mode, 2 flags |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| mode_o | output | 8 | Mode register readback |
| flag_uf_o | output | 1 | Timer underflow request flag |
| flag_pin_o | output | 1 | Pin edge request flag |
| pulse_o | output | 1 | Toggling pulse output |
| alt_o | output | 1 | Inverted pulse output for the secondary pin |
| alt_oe_o | output | 1 | Secondary pin driven by the timer when 1 |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, two synchronizer stages and the secondary-pin variant present. With an 8-bit counter a test can reach underflow in a handful of ticks, so reload, flag setting and pulse toggling are all covered without long runs. The two-stage synchronizer fixes a known pin-to-effect latency, and every pin change is followed by enough cycles to clear it. With the secondary-pin variant built in, the inverted output and its enable can be checked at the ports.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;
   typedef enum logic [1:0] {
      TM_PLAIN = 2'b00,
      TM_PULSE = 2'b01,
      TM_EVENT = 2'b10,
      TM_WIDTH = 2'b11
   } tm_mode_e;

   typedef struct packed {
      logic     alt_en;
      logic     pol;
      logic     stop;
      tm_mode_e mode;
   } tm_ctl_t;

   localparam int CTL_W = $bits(tm_ctl_t);

   localparam logic [1:0] ADDR_CNT  = 2'd0;
   localparam logic [1:0] ADDR_MODE = 2'd1;
   localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/modal_timer_pin_cond.sv
module modal_timer_pin_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic pol_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl_prev_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   // Qualified level: high means "pin is at the inactive counting level".
   assign lvl_o = pol_i ? sync_q[LAST] : ~sync_q[LAST];

   // Reset value matches the qualified level of a reset synchronizer with polarity 0.
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_prev_q <= 1'b1;
      else        lvl_prev_q <= lvl_o;

   assign rise_o = lvl_o & ~lvl_prev_q;
   assign fall_o = ~lvl_o & lvl_prev_q;
endmodule

// File: rtl/modal_timer_regs.sv
module modal_timer_regs
   import modal_timer_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [1:0]    wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          uf_evt_i,
   input  logic          pin_evt_i,
   output tm_ctl_t       ctl_o,
   output logic [DW-1:0] mode_rd_o,
   output logic          flag_uf_o,
   output logic          flag_pin_o
);
   tm_ctl_t ctl_q;
   logic    uf_q, pin_q;
   logic    wr_mode, wr_flag;

   assign wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);
   assign wr_flag = wr_en_i && (wr_addr_i == ADDR_FLAG);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       ctl_q <= '0;
      else if (wr_mode) ctl_q <= tm_ctl_t'(wr_data_i[CTL_W-1:0]);

   // Hardware set takes priority over a software write in the same cycle.
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         uf_q  <= 1'b0;
         pin_q <= 1'b0;
      end else begin
         if (uf_evt_i)     uf_q <= 1'b1;
         else if (wr_flag) uf_q <= wr_data_i[0];
         if (pin_evt_i)    pin_q <= 1'b1;
         else if (wr_flag) pin_q <= wr_data_i[1];
      end

   assign ctl_o      = ctl_q;
   assign mode_rd_o  = {{(DW-CTL_W){1'b0}}, ctl_q};
   assign flag_uf_o  = uf_q;
   assign flag_pin_o = pin_q;

   assert_uf_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt_i |=> flag_uf_o);
   assert_pin_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_evt_i |=> flag_pin_o);
   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && wr_data_i[1:0] == 2'b00 && !uf_evt_i && !pin_evt_i) |=> (!flag_uf_o && !flag_pin_o));
endmodule

// File: rtl/modal_timer_core.sv
module modal_timer_core
   import modal_timer_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tm_ctl_t          ctl_i,
   input  logic             tick_i,
   input  logic             lvl_i,
   input  logic             fall_i,
   input  logic             wr_cnt_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             uf_o,
   output logic             pulse_o
);
   logic [WIDTH-1:0] cnt_q, latch_q;
   logic             pulse_q;
   logic             step, cnt_en, load;

   always_comb begin
      case (ctl_i.mode)
         TM_EVENT: step = fall_i;
         TM_WIDTH: step = tick_i & ~lvl_i;
         default:  step = tick_i;
      endcase
   end

   assign cnt_en = step & ~ctl_i.stop;
   assign load   = wr_cnt_i & ctl_i.stop;
   assign uf_o   = cnt_en && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        latch_q <= '1;
      else if (wr_cnt_i) latch_q <= wr_data_i;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cnt_q <= '1;
      else if (load)   cnt_q <= wr_data_i;
      else if (uf_o)   cnt_q <= latch_q;
      else if (cnt_en) cnt_q <= cnt_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                               pulse_q <= 1'b0;
      else if (uf_o && ctl_i.mode == TM_PULSE)  pulse_q <= ~pulse_q;

   assign cnt_o   = cnt_q;
   assign pulse_o = pulse_q;

   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load) |=> $stable(cnt_o));
   assert_reload_on_uf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o |=> (cnt_o == $past(latch_q)));
   assert_pulse_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_o && ctl_i.mode == TM_PULSE) |=> (pulse_o != $past(pulse_o)));
   assert_pulse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.mode != TM_PULSE) |=> $stable(pulse_o));
endmodule

// File: rtl/modal_timer.sv
module modal_timer
   import modal_timer_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_ALT_PIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             pin_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic [WIDTH-1:0] mode_o,
   output logic             flag_uf_o,
   output logic             flag_pin_o,
   output logic             pulse_o,
   output logic             alt_o,
   output logic             alt_oe_o
);
   generate
      if (WIDTH < CTL_W) begin : g_bad_width
         $error("modal_timer: WIDTH must hold the mode register");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("modal_timer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   tm_ctl_t ctl;
   logic    lvl, rise, fall, uf, wr_cnt;

   assign wr_cnt = wr_en_i && (wr_addr_i == ADDR_CNT);

   modal_timer_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_i(ctl.pol),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   modal_timer_regs #(.DW(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .uf_evt_i(uf), .pin_evt_i(rise),
      .ctl_o(ctl), .mode_rd_o(mode_o), .flag_uf_o(flag_uf_o), .flag_pin_o(flag_pin_o)
   );

   modal_timer_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .tick_i(tick_i), .lvl_i(lvl),
      .fall_i(fall), .wr_cnt_i(wr_cnt), .wr_data_i(wr_data_i),
      .cnt_o(cnt_o), .uf_o(uf), .pulse_o(pulse_o)
   );

   generate
      if (HAS_ALT_PIN) begin : g_alt
         assign alt_oe_o = ctl.alt_en;
         assign alt_o    = ctl.alt_en & ~pulse_o;
      end else begin : g_no_alt
         assign alt_oe_o = 1'b0;
         assign alt_o    = 1'b0;
      end
   endgenerate

   assert_stop_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.stop && !wr_cnt) |=> $stable(cnt_o));
   assert_event_ignores_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.mode == TM_EVENT && !fall && !wr_cnt) |=> $stable(cnt_o));
endmodule

// File: tb/modal_timer_bench.sv
module modal_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       pin = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] cnt, mode_rd;
   logic       f_uf, f_pin, pulse, alt, alt_oe;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   modal_timer u_modal_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .pin_i(pin),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .cnt_o(cnt), .mode_o(mode_rd), .flag_uf_o(f_uf), .flag_pin_o(f_pin),
      .pulse_o(pulse), .alt_o(alt), .alt_oe_o(alt_oe)
   );

   // Fields: req(4) mode(8) pin(1) ticks(8) load(8) expected(8)
   localparam int NV = 9;
   localparam logic [36:0] VEC [NV] = '{
      {4'd3, 8'h00, 1'b0, 8'd5, 8'd20, 8'd15},  // R3 plain, pin low
      {4'd3, 8'h00, 1'b1, 8'd5, 8'd20, 8'd15},  // R3 plain, pin high
      {4'd4, 8'h03, 1'b1, 8'd5, 8'd20, 8'd15},  // R4 width pol0, pin high counts
      {4'd4, 8'h03, 1'b0, 8'd5, 8'd20, 8'd20},  // R4 width pol0, pin low holds
      {4'd4, 8'h0B, 1'b0, 8'd5, 8'd20, 8'd15},  // R4 width pol1, pin low counts
      {4'd4, 8'h0B, 1'b1, 8'd5, 8'd20, 8'd20},  // R4 width pol1, pin high holds
      {4'd5, 8'h02, 1'b1, 8'd5, 8'd20, 8'd20},  // R5 event, ticks ignored
      {4'd6, 8'h04, 1'b0, 8'd5, 8'd20, 8'd20},  // R6 stopped
      {4'd7, 8'h00, 1'b0, 8'd5, 8'd3,  8'd2}    // R7 underflow reload
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cnt, 8'hFF, "R1 cnt");
      chk(mode_rd, 8'h00, "R1 mode");
      chk({6'd0, f_pin, f_uf}, 8'h00, "R1 flags");
      chk({6'd0, alt_oe, pulse}, 8'h00, "R1 pulse/alt_oe");

      // R2 unused bits read back zero
      wr(2'd1, 8'hFF);
      chk(mode_rd, 8'h1F, "R2 readback");
      wr(2'd1, 8'h04);
      wr(2'd2, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [36:0] v;
         v = VEC[i];
         wr(2'd1, v[32:25] | 8'h04);
         pin = v[24];
         wr(2'd0, v[15:8]);
         settle();
         wr(2'd1, v[32:25]);
         ticks(int'(v[23:16]));
         wr(2'd1, v[32:25] | 8'h04);
         settle();
         chk(cnt, v[7:0], $sformatf("R%0d vector %0d", v[36:33], i));
      end
      chk({7'd0, f_uf}, 8'd1, "R7 flag set");
      chk({7'd0, pulse}, 8'd0, "R8 no toggle outside pulse mode");
      wr(2'd2, 8'h00);
      chk({6'd0, f_pin, f_uf}, 8'h00, "R10 flag clear");

      // R5 event edges, polarity 0: two rises, one fall
      wr(2'd1, 8'h06); pin = 1'b0; wr(2'd0, 8'd10); settle();
      wr(2'd1, 8'h02);
      pin = 1'b1; settle(); pin = 1'b0; settle(); pin = 1'b1; settle();
      wr(2'd1, 8'h06);
      chk(cnt, 8'd8, "R5 rising edges pol0");
      // R5 polarity 1: falling edges
      wr(2'd1, 8'h0E); pin = 1'b0; wr(2'd0, 8'd10); settle();
      wr(2'd1, 8'h0A);
      pin = 1'b1; settle(); pin = 1'b0; settle(); pin = 1'b1; settle();
      wr(2'd1, 8'h0E);
      chk(cnt, 8'd9, "R5 falling edges pol1");

      // R8 pulse output and secondary pin
      wr(2'd1, 8'h15); wr(2'd0, 8'd1);
      wr(2'd1, 8'h11);
      ticks(2);
      wr(2'd1, 8'h15);
      @(negedge clk);
      chk({7'd0, pulse}, 8'd1, "R8 pulse toggled");
      chk({6'd0, alt_oe, alt}, 8'b10, "R8 secondary pin");
      chk(cnt, 8'd1, "R7 reload in pulse mode");

      // R9 pin request edges, R12 sync latency
      wr(2'd1, 8'h04); pin = 1'b0; settle(); wr(2'd2, 8'h00);
      pin = 1'b1; settle();
      chk({7'd0, f_pin}, 8'd0, "R9 pol0 rising ignored");
      pin = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk({7'd0, f_pin}, 8'd0, "R12 not seen before sync");
      @(negedge clk);
      chk({7'd0, f_pin}, 8'd1, "R12 R9 pol0 falling after sync");
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h0C); settle();
      chk({7'd0, f_pin}, 8'd0, "R10 pol change pin low no request");
      pin = 1'b1; settle();
      chk({7'd0, f_pin}, 8'd1, "R9 pol1 rising");
      wr(2'd2, 8'h00);
      pin = 1'b0; settle();
      chk({7'd0, f_pin}, 8'd0, "R9 pol1 falling ignored");

      // R10 spurious request on polarity change with pin high
      wr(2'd1, 8'h04); pin = 1'b1; settle(); wr(2'd2, 8'h00); settle();
      chk({7'd0, f_pin}, 8'd0, "R10 pre-change");
      wr(2'd1, 8'h0C); settle();
      chk({7'd0, f_pin}, 8'd1, "R10 spurious request");
      wr(2'd2, 8'h00);
      chk({7'd0, f_pin}, 8'd0, "R10 spurious cleared");

      // R11 write while running loads only the latch
      wr(2'd1, 8'h04); wr(2'd0, 8'd30);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'd7);
      @(negedge clk);
      chk(cnt, 8'd30, "R11 running write not loaded");
      ticks(31);
      wr(2'd1, 8'h04);
      chk(cnt, 8'd7, "R11 new latch used at underflow");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule